// File: doc/BRIEF.md
# Two-Bank Interleaved Low-Power Memory

This block presents one synchronous single-port memory to its user and builds it from two half-size banks. The least significant address bit chooses the bank, so even word addresses live in one bank and odd word addresses in the other. The remaining address bits go to both banks as the row address. On every access only the addressed bank is enabled. The other bank sees no chip enable, no write enable and no output enable, so it does not switch.

Reads have one cycle of latency. The read-data multiplexer is steered by a small state machine. It has two states. `STEER_EVEN` points the multiplexer at the even bank and `STEER_ODD` points it at the odd bank. A read of an odd address moves the machine to `STEER_ODD`, and a read of an even address moves it to `STEER_EVEN`. Writes and idle cycles leave the state as it is. The state register therefore acts as the registered copy of the bank bit, and the multiplexer lines up with the banks' registered outputs. Reads may alternate between the banks on consecutive cycles with no bubble.

Each bank also has an access counter that the user can read. This lets an observer confirm that every access enabled exactly one bank. The address width is a parameter. A 15-bit address gives two banks of 16K words of 32 bits each. The default is a smaller size so that the block elaborates quickly.

Top module: `bank_split_mem`

## Requirements
- R1: Data written to an address with `acc_en`=1 and `wr_en`=1 is returned on `rdata` after a later read of that address (`acc_en`=1, `wr_en`=0). The data appears on `rdata` in the cycle right after the clock edge that accepted the read.
- R2: Address bit 0 selects the bank (0 = even bank, 1 = odd bank). Bits ADDR_W-1 down to 1 form the row address. Addresses 2k and 2k+1 are distinct storage locations.
- R3: During an access exactly one bank is enabled, the one that address bit 0 names. During a cycle with `acc_en`=0 neither bank is enabled.
- R4: `rdata` comes from the bank that was addressed by the most recent read. Reads that alternate between the banks on consecutive cycles each return their own data with no idle cycle between them.
- R5: A write changes only the addressed word. It does not change `rdata`, which keeps the value of the last read.
- R6: While `acc_en`=0, `rdata` holds its last value.
- R7: After reset, `rdata`, `even_hits` and `odd_hits` are all zero.
- R8: Each accepted access, read or write, adds one to `even_hits` when address bit 0 is 0, or to `odd_hits` when it is 1. Each counter wraps modulo 2^CNT_W. Idle cycles change neither counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read; used only when acc_en is 1 |
| addr | input | ADDR_W | Word address; bit 0 selects the bank |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one cycle after the read |
| even_hits | output | CNT_W | Number of accesses to the even bank |
| odd_hits | output | CNT_W | Number of accesses to the odd bank |

## Verification
The assertions check several properties on every cycle. They check that each access enables exactly one bank and that an idle cycle enables none. They check that `rdata` stays stable after a write or an idle cycle. They check that each counter steps by exactly the access that went to its bank, and that the steering state follows the bank bit of the last read. Whether the stored data is correct can only be shown by the bench's scenarios, which compare against a model of the written words. These scenarios include the two words that share one row, back-to-back reads that alternate banks, counter wrap-around, and random mixes of reads, writes and idle cycles.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    // Read-steering state: which bank drives the read-data multiplexer
    typedef enum logic {
        STEER_EVEN = 1'b0,
        STEER_ODD  = 1'b1
    } steer_t;

    // Control bundle delivered to one bank
    typedef struct packed {
        logic ce;    // chip enable, active high
        logic we;    // write enable, active high
        logic oe_n;  // output enable, active low
    } bank_ctl_t;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
    import bsm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_en,
    input  logic                        wr_en,
    input  logic                        bank_bit,
    output bank_ctl_t [NUM_BANKS-1:0]   ctl,
    output steer_t                      steer
);

    steer_t state, state_nxt;
    logic   rd_req;

    assign rd_req = acc_en && !wr_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= STEER_EVEN;
        else
            state <= state_nxt;
    end

    // Transitions: only a read moves the steering state
    always_comb begin
        state_nxt = state;
        unique case (state)
            STEER_EVEN: if (rd_req && bank_bit)  state_nxt = STEER_ODD;
            STEER_ODD:  if (rd_req && !bank_bit) state_nxt = STEER_EVEN;
            default:    state_nxt = STEER_EVEN;
        endcase
    end

    // Outputs: per-bank decode and steering
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            ctl[b].ce   = acc_en && (bank_bit == b[0]);
            ctl[b].we   = ctl[b].ce && wr_en;
            ctl[b].oe_n = !(ctl[b].ce && !wr_en);
        end
        steer = state;
    end

endmodule

// File: rtl/bsm_bank.sv
module bsm_bank
    import bsm_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_ctl_t         ctl,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout
);

    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] mem [0:ROWS-1];
    logic [DATA_W-1:0] dout_q;

    // Storage array: written only when this bank is enabled for a write
    always_ff @(posedge clk) begin
        if (ctl.ce && ctl.we)
            mem[row] <= wdata;
    end

    // Registered read port: loads only when enabled with output enable low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_q <= '0;
        else if (ctl.ce && !ctl.oe_n)
            dout_q <= mem[row];
    end

    assign dout = dout_q;

endmodule

// File: rtl/bsm_rmux.sv
module bsm_rmux
    import bsm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  steer_t                            sel,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  din,
    output logic [DATA_W-1:0]                 dout
);

    always_comb begin
        unique case (sel)
            STEER_EVEN: dout = din[0];
            STEER_ODD:  dout = din[1];
            default:    dout = din[0];
        endcase
    end

endmodule

// File: rtl/bsm_cnt.sv
module bsm_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (inc)
            count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/bank_split_mem.sv
module bank_split_mem
    import bsm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  even_hits,
    output logic [CNT_W-1:0]  odd_hits
);

    localparam int ROW_W = ADDR_W - 1;

    bank_ctl_t [NUM_BANKS-1:0]             ctl;
    logic      [NUM_BANKS-1:0]             bank_ce;
    logic      [NUM_BANKS-1:0][DATA_W-1:0] bank_dout;
    logic      [NUM_BANKS-1:0][CNT_W-1:0]  hits;
    steer_t                                steer;
    logic      [ROW_W-1:0]                 row;

    assign row = addr[ADDR_W-1:1];

    bsm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .wr_en    (wr_en),
        .bank_bit (addr[0]),
        .ctl      (ctl),
        .steer    (steer)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_ce[b] = ctl[b].ce;

        bsm_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[b]),
            .row   (row),
            .wdata (wdata),
            .dout  (bank_dout[b])
        );

        bsm_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ctl[b].ce),
            .count (hits[b])
        );
    end

    bsm_rmux #(
        .DATA_W (DATA_W)
    ) u_rmux (
        .sel  (steer),
        .din  (bank_dout),
        .dout (rdata)
    );

    assign even_hits = hits[0];
    assign odd_hits  = hits[1];

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk
    import bsm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  even_hits,
    input logic [CNT_W-1:0]  odd_hits,
    input logic [1:0]        bank_ce,
    input steer_t            steer
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> ($countones(bank_ce) == 1 && bank_ce[addr[0]])); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (bank_ce == 2'b00)); // R3

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en) |=> $stable(rdata)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(rdata)); // R6

    AST_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (even_hits == $past(even_hits) + CNT_W'($past(acc_en && !addr[0])))); // R8

    AST_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (odd_hits == $past(odd_hits) + CNT_W'($past(acc_en && addr[0])))); // R8

    AST_READ_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_en && !wr_en)) |-> (logic'(steer) == $past(addr[0]))); // R4

endmodule

bind bank_split_mem bsm_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .even_hits (even_hits),
    .odd_hits  (odd_hits),
    .bank_ce   (bank_ce),
    .steer     (steer)
);

// File: tb/sim_bank_split_mem.sv
`timescale 1ns/1ps
module sim_bank_split_mem;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [CNT_W-1:0]  even_hits, odd_hits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [DATA_W-1:0] model [0:DEPTH-1];
    bit                known [0:DEPTH-1];
    logic [DATA_W-1:0] exp_rd = '0;
    bit                exp_known = 1'b1;
    logic [CNT_W-1:0]  exp_even = '0, exp_odd = '0;

    always #2 clk = ~clk;

    bank_split_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .even_hits(even_hits), .odd_hits(odd_hits)
    );

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return c + CNT_W'(1);
    endfunction

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, apply model at posedge, check at next negedge
    task automatic cyc(input bit en, input bit we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input string tag);
        acc_en = en; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        if (en) begin
            if (we) begin
                model[a] = d; known[a] = 1'b1;
            end else begin
                exp_rd = model[a]; exp_known = known[a];
            end
            if (a[0]) exp_odd = bump(exp_odd);
            else      exp_even = bump(exp_even);
        end
        @(negedge clk);
        if (exp_known) chk(tag, rdata, exp_rd);
        chk("R8 even_hits", DATA_W'(even_hits), DATA_W'(exp_even));
        chk("R8 odd_hits", DATA_W'(odd_hits), DATA_W'(exp_odd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            known[i] = 1'b0; model[i] = '0;
        end
        void'($urandom(32'h5A17C3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 rdata", rdata, '0);
        chk("R7 even_hits", DATA_W'(even_hits), '0);
        chk("R7 odd_hits", DATA_W'(odd_hits), '0);

        // R2: two words of one row are separate
        cyc(1, 1, 10'd10, 32'hAAAA_0010, "R5 write");
        cyc(1, 1, 10'd11, 32'hBBBB_0011, "R5 write");
        cyc(1, 0, 10'd10, '0, "R2 even word");
        cyc(1, 0, 10'd11, '0, "R2 odd word");
        // R4: alternating reads back-to-back
        cyc(1, 1, 10'd20, 32'h1234_0020, "R5 write");
        cyc(1, 1, 10'd21, 32'h1234_0021, "R5 write");
        for (int k = 0; k < 6; k++)
            cyc(1, 0, (k % 2 == 0) ? 10'd20 : 10'd21, '0, "R4 alternate");
        // R5: write to the other bank right after a read keeps rdata
        cyc(1, 0, 10'd10, '0, "R1 read");
        cyc(1, 1, 10'd11, 32'hCAFE_F00D, "R5 rdata held over write");
        cyc(1, 1, 10'd10, 32'hDEAD_BEEF, "R5 rdata held over write");
        cyc(1, 0, 10'd11, '0, "R1 new odd word");
        cyc(1, 0, 10'd10, '0, "R1 new even word");
        // R6: idle cycles hold rdata and counters (R3: no bank touched)
        for (int k = 0; k < 4; k++)
            cyc(0, k[0], 10'(k + 1), 32'hFFFF_FFFF, "R6 idle hold");
        cyc(1, 0, 10'd11, '0, "R3 only odd bank written");
        // Random mix, covers counter wrap (CNT_W=8)
        for (int k = 0; k < 3000; k++) begin
            bit en = ($urandom % 4) != 0;
            bit we = ($urandom % 2) == 1;
            logic [ADDR_W-1:0] a = ADDR_W'($urandom % 64);
            cyc(en, we, a, $urandom, "R1 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule